// File: doc/BRIEF.md
# Dual-Channel Compare-Match Up-Timer

This block provides two independent 16-bit periodic timers behind a small 16-bit register window. Each channel divides the peripheral clock by a selectable ratio, counts up on every divided tick, and compares the count against a programmable limit. When the count has reached the limit, the next tick returns it to zero. If the channel's interrupt enable is set, the channel also emits a single-cycle interrupt pulse at that moment. A shared run register starts and stops the channels one bit at a time.

Software programs the divider, the interrupt enable, the limit and, when needed, the count value. It then sets the channel's run bit. The interrupt period is (limit + 1) × divider clocks. Reads are registered: the data for a read access appears on the read bus one clock after the access. In every cycle without a read, the read bus is zero.

Top module: `mtimer_dual`

## Requirements
- R1: Registers sit at byte offsets 0 (run register), 2/4/6 (channel 0 control/count/limit) and 8/10/12 (channel 1 control/count/limit). A read returns the addressed register one clock after the access cycle, and the read bus is zero in every other cycle.
- R2: Bit n of the run register runs (1) or stops (0) channel n. Reading it returns the run bits in the low bits, with all upper bits zero.
- R3: Control bits [1:0] select the divider 8 << (2 × sel), that is 8, 32, 128 or 512 clocks per count step. A running channel's counter first advances at the divider-th clock edge after the edge that sets its run bit.
- R4: Control bit 7 always reads 1. Only bits [1:0] and bit 6 are writable, and every other bit reads 0.
- R5: After reset the limit is 0xFFFF and the count is 0. The count increments on each tick and returns to 0 on the tick after it equals the limit, so the period is (limit + 1) ticks.
- R6: With control bit 6 set, the channel drives a one-clock pulse on its interrupt output in the cycle the count returns to 0 from the limit. With bit 6 clear, no pulse is driven.
- R7: A count write takes effect at the clock edge of the write, overrides a tick in that cycle, and raises no interrupt from that edge. A written value equal to the limit wraps and pulses on the next tick.
- R8: A stopped channel holds its count. Its divider restarts from zero when the channel runs again.
- R9: An access with address bit 0 set, or to byte offset 14, is ignored: writes change nothing and reads return 0.
- R10: A synchronous reset clears the run bits, control fields, counts and interrupt outputs, and sets both limits back to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address in the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_pulse | output | 2 | Per-channel compare-match interrupt pulse |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit counts and a two-bit divider select. With these values all four divider ratios, up to 512 clocks per step, fit inside a short run. The unused word at offset 14 is also reachable as an address hole. Small limits keep whole match periods short enough to measure exactly from the run write. Channel isolation is checked by running one channel while reconfiguring or reading the other.

// File: rtl/mtimer_pkg.sv
`timescale 1ns/1ps
package mtimer_pkg;
  localparam int DATA_W     = 16;
  localparam int SEL_W      = 2;
  localparam int BASE_SHIFT = 3;
  localparam int STEP_SHIFT = 2;
  localparam int IE_BIT     = 6;
  localparam int ONE_BIT    = 7;
  localparam int REGS_PER_CH = 3;

  typedef enum logic [1:0] {
    KIND_CTRL  = 2'd0,
    KIND_COUNT = 2'd1,
    KIND_LIMIT = 2'd2,
    KIND_NONE  = 2'd3
  } kind_e;

  typedef struct packed {
    logic             irq_en;
    logic [SEL_W-1:0] div_sel;
  } ctrl_t;
endpackage

// File: rtl/mtimer_decode.sv
`timescale 1ns/1ps
module mtimer_decode
  import mtimer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              start_hit,
  output logic [NUM_CH-1:0] ch_hit,
  output kind_e             kind
);
  logic [ADDR_W-2:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:1];
  assign aligned = sel && !addr[0];

  always_comb begin
    start_hit = aligned && (word == '0);
    ch_hit    = '0;
    kind      = KIND_NONE;
    for (int i = 0; i < NUM_CH; i++) begin
      if (aligned && (int'(word) >= 1 + REGS_PER_CH*i) &&
          (int'(word) < 1 + REGS_PER_CH*(i+1))) begin
        ch_hit[i] = 1'b1;
        kind      = kind_e'(2'(int'(word) - (1 + REGS_PER_CH*i)));
      end
    end
  end
endmodule

// File: rtl/mtimer_prescale.sv
`timescale 1ns/1ps
module mtimer_prescale
  import mtimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = BASE_SHIFT + STEP_SHIFT*((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   last;

  always_comb begin
    last = ((PRE_W+1)'(1) << (BASE_SHIFT + STEP_SHIFT*int'(div_sel))) - (PRE_W+1)'(1);
    tick = run && ({1'b0, pre_q} >= last);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/mtimer_channel.sv
`timescale 1ns/1ps
module mtimer_channel
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ctrl_we,
  input  logic              cnt_we,
  input  logic              lim_we,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             irq_q;
  logic             tick;
  logic             hit;

  mtimer_prescale u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .div_sel (ctrl_q.div_sel),
    .tick    (tick)
  );

  assign hit = (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      lim_q  <= '1;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= tick && hit && ctrl_q.irq_en && !cnt_we;
      if (cnt_we)    cnt_q <= wdata[CNT_W-1:0];
      else if (tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      if (lim_we)    lim_q <= wdata[CNT_W-1:0];
      if (ctrl_we) begin
        ctrl_q.irq_en  <= wdata[IE_BIT];
        ctrl_q.div_sel <= wdata[SEL_W-1:0];
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign irq_o  = irq_q;

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hit && !cnt_we) |=> (cnt_q == '0));
  // R6
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (cnt_q == '0));
  // R6
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R8
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt_q));
  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> ((cnt_q == $past(wdata[CNT_W-1:0])) && !irq_q));
endmodule

// File: rtl/mtimer_dual.sv
`timescale 1ns/1ps
module mtimer_dual
  import mtimer_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int CNT_W  = 16,
  localparam int ADDR_W = $clog2(2*(1 + REGS_PER_CH*NUM_CH))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_pulse
);
  logic [NUM_CH-1:0] run_q;
  logic              start_hit;
  logic [NUM_CH-1:0] ch_hit;
  kind_e             kind;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rdata_q;

  ctrl_t             ch_ctrl [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
  logic [CNT_W-1:0]  ch_lim  [NUM_CH];

  mtimer_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .sel       (bus_sel),
    .addr      (bus_addr),
    .start_hit (start_hit),
    .ch_hit    (ch_hit),
    .kind      (kind)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mtimer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .run     (run_q[g]),
      .ctrl_we (bus_wr && ch_hit[g] && (kind == KIND_CTRL)),
      .cnt_we  (bus_wr && ch_hit[g] && (kind == KIND_COUNT)),
      .lim_we  (bus_wr && ch_hit[g] && (kind == KIND_LIMIT)),
      .wdata   (bus_wdata),
      .ctrl_o  (ch_ctrl[g]),
      .cnt_o   (ch_cnt[g]),
      .lim_o   (ch_lim[g]),
      .irq_o   (irq_pulse[g])
    );
  end

  always_comb begin
    rd_d = '0;
    if (start_hit) rd_d[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (kind)
          KIND_CTRL: begin
            rd_d[ONE_BIT]     = 1'b1;
            rd_d[IE_BIT]      = ch_ctrl[i].irq_en;
            rd_d[SEL_W-1:0]   = ch_ctrl[i].div_sel;
          end
          KIND_COUNT: rd_d = DATA_W'(ch_cnt[i]);
          KIND_LIMIT: rd_d = DATA_W'(ch_lim[i]);
          default:    rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && start_hit) run_q <= bus_wdata[NUM_CH-1:0];
      rdata_q <= (bus_sel && !bus_wr) ? rd_d : '0;
    end
  end

  assign bus_rdata = rdata_q;

  // R4
  ctrl_bit7_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && (|ch_hit) && (kind == KIND_CTRL)) |=> bus_rdata[ONE_BIT]);
  // R9
  odd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr[0]) |=> (bus_rdata == '0));
  // R2
  start_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && start_hit) |=> (bus_rdata == DATA_W'($past(run_q))));
  // R1
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (bus_rdata == '0));
endmodule

// File: tb/mtimer_dual_test.sv
`timescale 1ns/1ps
module mtimer_dual_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr  = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit armed = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  mtimer_dual uut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_pulse(irq)
  );

  // behavioural reference model
  int m_run[2], m_pre[2], m_cnt[2], m_lim[2], m_div[2], m_ie[2], m_irq[2];
  int m_rd;

  always @(posedge clk) begin
    int w, ch, k, nrd, tick, cw;
    bit ok;
    if (rst) begin
      for (int n = 0; n < 2; n++) begin
        m_run[n] = 0; m_pre[n] = 0; m_cnt[n] = 0; m_lim[n] = 16'hFFFF;
        m_div[n] = 0; m_ie[n] = 0; m_irq[n] = 0;
      end
      m_rd = 0;
    end else begin
      ok = sel && !addr[0];
      w = int'(addr) >> 1;
      ch = -1; k = -1;
      if (ok && w >= 1 && w <= 6) begin ch = (w-1)/3; k = (w-1)%3; end
      nrd = 0;
      if (sel && !wr && ok) begin
        if (w == 0) nrd = m_run[0] | (m_run[1] << 1);
        else if (ch >= 0) begin
          if (k == 0) nrd = 128 | (m_ie[ch] << 6) | m_div[ch];
          else if (k == 1) nrd = m_cnt[ch];
          else nrd = m_lim[ch];
        end
      end
      m_rd = nrd;
      for (int n = 0; n < 2; n++) begin
        tick = (m_run[n] != 0 && m_pre[n] >= (8 << (2*m_div[n])) - 1) ? 1 : 0;
        cw = (sel && wr && ch == n && k == 1) ? 1 : 0;
        m_irq[n] = (tick && m_cnt[n] == m_lim[n] && m_ie[n] && !cw) ? 1 : 0;
        if (!m_run[n] || tick) m_pre[n] = 0; else m_pre[n]++;
        if (cw) m_cnt[n] = int'(wdata);
        else if (tick) m_cnt[n] = (m_cnt[n] == m_lim[n]) ? 0 : m_cnt[n] + 1;
        if (sel && wr && ch == n && k == 0) begin
          m_div[n] = int'(wdata) & 3; m_ie[n] = (int'(wdata) >> 6) & 1;
        end
        if (sel && wr && ch == n && k == 2) m_lim[n] = int'(wdata);
      end
      if (sel && wr && ok && w == 0) begin
        m_run[0] = int'(wdata[0]); m_run[1] = int'(wdata[1]);
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      n_chk++;
      if (int'(rdata) != m_rd) begin
        n_bad++;
        $display("FAIL R1 model rdata: actual %h expected %h at %0t", rdata, m_rd, $time);
      end
      n_chk++;
      if (int'(irq) != (m_irq[0] | (m_irq[1] << 1))) begin
        n_bad++;
        $display("FAIL R6 model irq: actual %b expected %0d%0d at %0t",
                 irq, m_irq[1], m_irq[0], $time);
      end
    end
  end

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    sel = 1; wr = 1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bus_read(int a, output int d);
    @(negedge clk);
    sel = 1; wr = 0; addr = 4'(a);
    @(negedge clk);
    d = int'(rdata);
    sel = 0;
  endtask

  task automatic wait_irq(int n, int maxk, output int k_out);
    k_out = -1;
    for (int k = 1; k <= maxk; k++) begin
      @(negedge clk);
      if (irq[n]) begin k_out = k; break; end
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, a, b, k;
    repeat (3) @(negedge clk);
    rst = 0;
    armed = 1;

    // reset state (R10, R2, R4, R5)
    bus_read(0, v);  check("R2 run bits after reset", v, 0);
    bus_read(2, v);  check("R4 ctrl0 after reset", v, 16'h0080);
    bus_read(6, v);  check("R5 limit0 after reset", v, 16'hFFFF);
    bus_read(4, v);  check("R5 count0 after reset", v, 0);

    // R4 writable mask
    bus_write(2, 16'hFFFF);
    bus_read(2, v);  check("R4 ctrl0 mask", v, 16'h00C3);

    // R1 map: channel 1 limit and control
    bus_write(12, 16'hABCD);
    bus_read(12, v); check("R1 limit1 at offset 12", v, 16'hABCD);
    bus_read(6, v);  check("R1 limit0 untouched", v, 16'hFFFF);
    bus_write(8, 16'h0041);
    bus_read(8, v);  check("R1 ctrl1 at offset 8", v, 16'h00C1);

    // R5/R6 period with div 8, limit 3
    bus_write(2, 16'h0040); bus_write(6, 3); bus_write(4, 0);
    bus_write(0, 1);
    wait_irq(0, 200, k); check("R6 first pulse ch0 div8 lim3", k, 32);
    @(negedge clk); check("R6 pulse width", int'(irq[0]), 0);
    wait_irq(0, 200, k); check("R5 period ch0", k, 31);
    bus_read(0, v);  check("R2 run readback", v, 1);

    // R3 dividers on ch1, ch0 stopped
    bus_write(0, 0);
    bus_write(12, 1); bus_write(10, 0); bus_write(8, 16'h0041);
    bus_write(0, 2);
    wait_irq(1, 400, k); check("R3 div32 lim1", k, 64);
    bus_write(0, 0); bus_write(10, 0); bus_write(12, 0); bus_write(8, 16'h0042);
    bus_write(0, 2);
    wait_irq(1, 400, k); check("R3 div128 lim0", k, 128);
    bus_write(0, 0); bus_write(10, 0); bus_write(8, 16'h0043);
    bus_write(0, 2);
    wait_irq(1, 1000, k); check("R3 div512 lim0", k, 512);

    // R6 no pulse when disabled
    bus_write(0, 0); bus_write(8, 16'h0000); bus_write(12, 1); bus_write(10, 0);
    bus_write(0, 2);
    a = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (irq[1]) a++; end
    check("R6 disabled channel pulses", a, 0);

    // R8 hold while stopped
    bus_write(0, 0);
    bus_read(10, a);
    repeat (50) @(negedge clk);
    bus_read(10, b);
    check("R8 count held while stopped", b, a);

    // R7 immediate count write
    bus_write(4, 16'h1234);
    bus_read(4, v);  check("R7 count write readback", v, 16'h1234);
    bus_write(6, 5); bus_write(4, 5);
    bus_write(0, 1);
    wait_irq(0, 100, k); check("R7 written value equal to limit wraps", k, 8);

    // R9 ignored accesses
    bus_write(3, 16'h00FF);
    bus_read(2, v);  check("R9 odd write ignored", v, 16'h00C0);
    bus_read(5, v);  check("R9 odd read zero", v, 0);
    bus_write(14, 16'hFFFF);
    bus_read(14, v); check("R9 offset 14 read zero", v, 0);
    bus_read(12, v); check("R9 offset 14 write ignored", v, 1);

    // R10 reset mid-run
    bus_write(0, 3);
    repeat (20) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    bus_read(0, v);  check("R10 run cleared", v, 0);
    bus_read(8, v);  check("R10 ctrl1 cleared", v, 16'h0080);
    bus_read(12, v); check("R10 limit1 restored", v, 16'hFFFF);
    bus_read(4, v);  check("R10 count0 cleared", v, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule